// File: doc/BRIEF.md
# Register Status Table Renamer

This block renames the register operands of a dispatch stage that serves 32 architectural registers. A status table keeps one entry per register. The entry is either idle, meaning the register file copy is current, or pending, meaning it holds the tag of the instruction that will produce the next value. For each presented instruction the block resolves both source operands at once. An idle source yields its register file value. A pending source yields the producer's tag, and a flag tells the receiving queue which of the two it got. When an instruction that writes a register dispatches, the block takes one tag from an external tag pool and records it against the destination register.

A common data bus delivers results as a tag and a value. When the broadcast tag is still the one recorded for some register, the value is written into the register file and that entry returns to idle. A broadcast that matches no current entry changes nothing, which covers results that a later writer has superseded. A source lookup in the same cycle as a matching broadcast takes the broadcast value directly, so a queue never receives a tag whose value is already on the bus. Dispatch is held after a conditional branch until a branch-resolution broadcast arrives. It is also held while an instruction needs a tag and the pool is empty.

Top module: `rename_stage`

## Requirements
- R1: After reset every register reads as value 0 with the tag flag low (flag 1 = tag, 0 = value).
- R2: A source whose entry is idle returns the register file value with the tag flag 0.
- R3: A source whose entry is pending returns the most recently recorded tag for that register with the tag flag 1.
- R4: An accepted instruction with the write flag set and a nonzero destination pulses tag_take in that cycle and records tag_in as the pending tag of the destination. Instructions with the write flag clear (stores, jumps, branches) take no tag.
- R5: A register broadcast (cdb_valid=1, cdb_is_branch=0) whose tag equals a pending entry's tag writes cdb_value to that register and returns the entry to idle from the next cycle.
- R6: A register broadcast whose tag matches no current entry, including a tag since replaced by a newer writer, changes no entry and no register value.
- R7: In a cycle where a source's pending tag equals the register broadcast tag, that source returns cdb_value with the tag flag 0.
- R8: When an accepted write to register r and a broadcast matching r's current tag fall in the same cycle, r is left pending with the new tag.
- R9: Register 0 is never made pending and always reads as value 0, and a write to register 0 takes no tag.
- R10: After a branch (disp_is_branch=1) is accepted, disp_fire stays 0 up to and including the cycle of the next branch-resolution broadcast (cdb_valid=1, cdb_is_branch=1), and dispatch may resume in the cycle after.
- R11: An instruction that needs a tag is not accepted while tag_avail is 0. An instruction that needs none is still accepted.
- R12: An instruction that is not accepted takes no tag and changes no status entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | An instruction is presented for dispatch |
| disp_src_a | input | 5 | First source register index |
| disp_src_b | input | 5 | Second source register index |
| disp_dst | input | 5 | Destination register index |
| disp_writes | input | 1 | Instruction writes its destination register |
| disp_is_branch | input | 1 | Instruction is a conditional branch |
| disp_fire | output | 1 | Presented instruction is accepted this cycle |
| tag_avail | input | 1 | Tag pool holds at least one tag |
| tag_in | input | 6 | Tag the pool offers next |
| tag_take | output | 1 | Pop the offered tag this cycle |
| src_a_is_tag | output | 1 | First source is a tag (1) or a value (0) |
| src_a_val | output | 32 | First source value, meaningful when the flag is 0 |
| src_a_tag | output | 6 | First source producer tag, meaningful when the flag is 1 |
| src_b_is_tag | output | 1 | Second source is a tag (1) or a value (0) |
| src_b_val | output | 32 | Second source value, meaningful when the flag is 0 |
| src_b_tag | output | 6 | Second source producer tag, meaningful when the flag is 1 |
| cdb_valid | input | 1 | Broadcast present on the common data bus |
| cdb_is_branch | input | 1 | Broadcast is a branch resolution, not a register result |
| cdb_tag | input | 6 | Tag of the broadcast result |
| cdb_value | input | 32 | Value of the broadcast result |

## Verification
Two things can land in the same cycle: a dispatch and a register broadcast. The broadcast can touch the sources being looked up, or the very register the dispatch is about to retag. Directed sequences set up both cases on purpose. One broadcasts a producer's tag while a consumer of that register dispatches, and the bench expects the value with the flag low. Another broadcasts a register's live tag while a new writer to that register dispatches, and the bench expects the newer tag to remain. A long seeded random run then mixes live tags, retired tags, branch resolutions and an empty pool. Every output is judged each cycle against a bench model of the status table and register file.

// File: rtl/rn_pkg.sv
// Shared defaults and types for the register renamer.
// Assumes: all modules take widths as parameters; these are defaults only.
package rn_pkg;
    localparam int unsigned RN_ARCH_REGS = 32;
    localparam int unsigned RN_DATA_W    = 32;
    localparam int unsigned RN_TAG_W     = 6;
    localparam int unsigned RN_NUM_SRC   = 2;

    // Kind of operand handed to an execution queue.
    typedef enum logic {
        SRC_IS_VALUE = 1'b0,
        SRC_IS_TAG   = 1'b1
    } src_kind_e;
endpackage

// File: rtl/rn_status_table.sv
// Per-register status table: pending flag and producer tag for each register.
// Allocation writes a new tag; a matching broadcast clears the entry.
// Allocation wins over a clear on the same entry in the same cycle.
// Assumes: register 0 is hard idle; live tags are unique (pool hands out each once).
module rn_status_table #(
    parameter int unsigned NREGS = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned TAG_W = rn_pkg::RN_TAG_W,
    parameter int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_en,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic                         bc_en,
    input  logic [TAG_W-1:0]             bc_tag,
    output logic [NREGS-1:0]             busy_o,
    output logic [NREGS-1:0][TAG_W-1:0]  tag_o,
    output logic                         hit_en,
    output logic [IDX_W-1:0]             hit_idx
);
    logic [NREGS-1:0] hit_vec;

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign busy_o[g] = 1'b0;
            assign tag_o[g]  = '0;
        end else begin : g_live
            logic             busy_r;
            logic [TAG_W-1:0] tag_r;
            logic             sel_alloc;

            assign sel_alloc = alloc_en && (alloc_idx == IDX_W'(g));

            // Entry update: allocate new tag, else clear on matching broadcast.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy_r <= 1'b0;
                    tag_r  <= '0;
                end else if (sel_alloc) begin
                    busy_r <= 1'b1;
                    tag_r  <= alloc_tag;
                end else if (hit_vec[g]) begin
                    busy_r <= 1'b0;
                end
            end

            assign busy_o[g] = busy_r;
            assign tag_o[g]  = tag_r;
        end
        assign hit_vec[g] = bc_en && busy_o[g] && (tag_o[g] == bc_tag);
    end

    // Encode the (at most one) entry that the broadcast completes.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        hit_en = |hit_vec;
    end

    // A broadcast completes at most one register when tags are unique.
    assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // An allocation leaves the destination pending with the offered tag.
    assert_alloc_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && alloc_idx != '0) |=>
        (busy_o[$past(alloc_idx)] && tag_o[$past(alloc_idx)] == $past(alloc_tag)));

    // A completed entry is idle next cycle unless retagged at the same time.
    assert_hit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !(alloc_en && alloc_idx == hit_idx)) |=> !busy_o[$past(hit_idx)]);
endmodule

// File: rtl/rn_regfile.sv
// Architectural register file with one write port and all contents visible.
// Assumes: register 0 is constant zero; writes only come from completed broadcasts.
module rn_regfile #(
    parameter int unsigned NREGS  = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned DATA_W = rn_pkg::RN_DATA_W,
    parameter int unsigned IDX_W  = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NREGS-1:0][DATA_W-1:0]  rd_all
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign rd_all[g] = '0;
        end else begin : g_live
            logic [DATA_W-1:0] val_r;

            // Register storage: cleared on reset, loaded on a broadcast write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_r <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    val_r <= wr_data;
                end
            end
            assign rd_all[g] = val_r;
        end
    end

    // A write to a nonzero register is visible in the next cycle.
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |=> (rd_all[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/rn_src_lookup.sv
// One source operand port: returns a value or a pending tag for a register index.
// A broadcast completing the looked-up register is forwarded as a value.
// Assumes: status and register file inputs reflect state before this cycle's edge.
module rn_src_lookup #(
    parameter int unsigned NREGS  = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned DATA_W = rn_pkg::RN_DATA_W,
    parameter int unsigned TAG_W  = rn_pkg::RN_TAG_W,
    parameter int unsigned IDX_W  = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              idx,
    input  logic [NREGS-1:0]              busy_all,
    input  logic [NREGS-1:0][TAG_W-1:0]   tag_all,
    input  logic [NREGS-1:0][DATA_W-1:0]  rf_all,
    input  logic                          bc_en,
    input  logic [TAG_W-1:0]              bc_tag,
    input  logic [DATA_W-1:0]             bc_value,
    output rn_pkg::src_kind_e             kind,
    output logic [DATA_W-1:0]             val,
    output logic [TAG_W-1:0]              tag
);
    logic pend;
    logic on_bus;

    // Select value, bypassed value or tag for the indexed register.
    always_comb begin
        pend   = busy_all[idx];
        tag    = tag_all[idx];
        on_bus = pend && bc_en && (tag_all[idx] == bc_tag);
        if (on_bus) begin
            kind = rn_pkg::SRC_IS_VALUE;
            val  = bc_value;
        end else if (pend) begin
            kind = rn_pkg::SRC_IS_TAG;
            val  = '0;
        end else begin
            kind = rn_pkg::SRC_IS_VALUE;
            val  = rf_all[idx];
        end
    end

    // A tag is only handed out for a register whose entry is pending.
    assert_tag_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == rn_pkg::SRC_IS_TAG) |-> busy_all[idx]);
endmodule

// File: rtl/rn_dispatch_ctrl.sv
// Dispatch acceptance: holds after a branch until its resolution broadcast,
// and holds a tag-needing instruction while the pool is empty.
// Assumes: one branch outstanding at a time; resolution broadcast is a single pulse.
module rn_dispatch_ctrl #(
    parameter int unsigned IDX_W = $clog2(rn_pkg::RN_ARCH_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [IDX_W-1:0] disp_dst,
    input  logic             disp_writes,
    input  logic             disp_is_branch,
    input  logic             tag_avail,
    input  logic             br_resolve,
    output logic             fire,
    output logic             take
);
    logic br_wait_q;
    logic need_tag;

    // Acceptance decision for the presented instruction.
    always_comb begin
        need_tag = disp_writes && (disp_dst != '0);
        fire     = disp_valid && !br_wait_q && !(need_tag && !tag_avail);
        take     = fire && need_tag;
    end

    // Branch hold flag: set by an accepted branch, cleared by its resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_wait_q <= 1'b0;
        end else if (fire && disp_is_branch) begin
            br_wait_q <= 1'b1;
        end else if (br_resolve) begin
            br_wait_q <= 1'b0;
        end
    end

    // Nothing is accepted in the cycle after a branch is accepted.
    assert_branch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && disp_is_branch) |=> !fire);

    // A tag is never popped from an empty pool.
    assert_pool_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> tag_avail);
endmodule

// File: rtl/rename_stage.sv
// Top of the register renamer: status table, register file, two source
// lookups with broadcast bypass, and dispatch acceptance control.
// Assumes: the tag pool never offers a tag that is still pending in the table.
module rename_stage #(
    parameter int unsigned NREGS  = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned DATA_W = rn_pkg::RN_DATA_W,
    parameter int unsigned TAG_W  = rn_pkg::RN_TAG_W,
    parameter int unsigned IDX_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [IDX_W-1:0]  disp_src_a,
    input  logic [IDX_W-1:0]  disp_src_b,
    input  logic [IDX_W-1:0]  disp_dst,
    input  logic              disp_writes,
    input  logic              disp_is_branch,
    output logic              disp_fire,
    input  logic              tag_avail,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              tag_take,
    output logic              src_a_is_tag,
    output logic [DATA_W-1:0] src_a_val,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_b_is_tag,
    output logic [DATA_W-1:0] src_b_val,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              cdb_valid,
    input  logic              cdb_is_branch,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value
);
    localparam int unsigned NSRC = rn_pkg::RN_NUM_SRC;

    logic                          reg_bc;
    logic                          br_resolve;
    logic [NREGS-1:0]              busy_all;
    logic [NREGS-1:0][TAG_W-1:0]   tag_all;
    logic [NREGS-1:0][DATA_W-1:0]  rf_all;
    logic                          hit_en;
    logic [IDX_W-1:0]              hit_idx;

    logic [NSRC-1:0][IDX_W-1:0]    src_idx;
    rn_pkg::src_kind_e             src_kind [NSRC];
    logic [NSRC-1:0][DATA_W-1:0]   src_val;
    logic [NSRC-1:0][TAG_W-1:0]    src_tag;

    assign reg_bc     = cdb_valid && !cdb_is_branch;
    assign br_resolve = cdb_valid && cdb_is_branch;
    assign src_idx[0] = disp_src_a;
    assign src_idx[1] = disp_src_b;

    rn_dispatch_ctrl #(.IDX_W(IDX_W)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .disp_valid     (disp_valid),
        .disp_dst       (disp_dst),
        .disp_writes    (disp_writes),
        .disp_is_branch (disp_is_branch),
        .tag_avail      (tag_avail),
        .br_resolve     (br_resolve),
        .fire           (disp_fire),
        .take           (tag_take)
    );

    rn_status_table #(.NREGS(NREGS), .TAG_W(TAG_W), .IDX_W(IDX_W)) rst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (tag_take),
        .alloc_idx (disp_dst),
        .alloc_tag (tag_in),
        .bc_en     (reg_bc),
        .bc_tag    (cdb_tag),
        .busy_o    (busy_all),
        .tag_o     (tag_all),
        .hit_en    (hit_en),
        .hit_idx   (hit_idx)
    );

    rn_regfile #(.NREGS(NREGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit_en),
        .wr_idx  (hit_idx),
        .wr_data (cdb_value),
        .rd_all  (rf_all)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rn_src_lookup #(.NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) lk_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (src_idx[s]),
            .busy_all (busy_all),
            .tag_all  (tag_all),
            .rf_all   (rf_all),
            .bc_en    (reg_bc),
            .bc_tag   (cdb_tag),
            .bc_value (cdb_value),
            .kind     (src_kind[s]),
            .val      (src_val[s]),
            .tag      (src_tag[s])
        );
    end

    assign src_a_is_tag = (src_kind[0] == rn_pkg::SRC_IS_TAG);
    assign src_a_val    = src_val[0];
    assign src_a_tag    = src_tag[0];
    assign src_b_is_tag = (src_kind[1] == rn_pkg::SRC_IS_TAG);
    assign src_b_val    = src_val[1];
    assign src_b_tag    = src_tag[1];

    // Register 0 is never handed out as a tag.
    assert_zero_reg_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_src_a == '0) |-> (!src_a_is_tag && src_a_val == '0));
endmodule

// File: tb/rename_stage_tb.sv
`timescale 1ns/1ps
module rename_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid, disp_writes, disp_is_branch;
    logic [4:0]  disp_src_a, disp_src_b, disp_dst;
    logic        disp_fire;
    logic        tag_avail;
    logic [5:0]  tag_in;
    logic        tag_take;
    logic        src_a_is_tag, src_b_is_tag;
    logic [31:0] src_a_val, src_b_val;
    logic [5:0]  src_a_tag, src_b_tag;
    logic        cdb_valid, cdb_is_branch;
    logic [5:0]  cdb_tag;
    logic [31:0] cdb_value;

    int total = 0;
    int bad   = 0;

    // Bench model of the status table and register file.
    bit          m_busy [32];
    logic [5:0]  m_tag  [32];
    logic [31:0] m_rf   [32];
    bit          m_wait;
    int          tag_ctr;

    always #2.5 clk = ~clk;

    rename_stage dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .disp_dst(disp_dst), .disp_writes(disp_writes), .disp_is_branch(disp_is_branch),
        .disp_fire(disp_fire), .tag_avail(tag_avail), .tag_in(tag_in), .tag_take(tag_take),
        .src_a_is_tag(src_a_is_tag), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
        .src_b_is_tag(src_b_is_tag), .src_b_val(src_b_val), .src_b_tag(src_b_tag),
        .cdb_valid(cdb_valid), .cdb_is_branch(cdb_is_branch), .cdb_tag(cdb_tag),
        .cdb_value(cdb_value)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit tag_live(input logic [5:0] t);
        for (int j = 1; j < 32; j++) if (m_busy[j] && m_tag[j] == t) return 1;
        return 0;
    endfunction

    // Next tag the pool offers: never one still pending.
    function automatic logic [5:0] pool_next();
        for (int k = 0; k < 64; k++) begin
            logic [5:0] t;
            t = 6'(tag_ctr + k);
            if (!tag_live(t)) return t;
        end
        return 6'd0;
    endfunction

    // Check one source port against the model.
    task automatic chk_src(input string nm, input logic [4:0] s, input bit bc,
                           input logic [5:0] ct, input logic [31:0] cv,
                           input logic it, input logic [31:0] v, input logic [5:0] t);
        bit    byp;
        string req;
        byp = m_busy[s] && bc && m_tag[s] == ct;
        if (s == 0)         req = "R9";
        else if (byp)       req = "R7";
        else if (m_busy[s]) req = "R3";
        else                req = "R2";
        chk({req, " flag ", nm}, 64'(it), 64'(m_busy[s] && !byp));
        if (m_busy[s] && !byp) chk({req, " tag ", nm}, 64'(t), 64'(m_tag[s]));
        else chk({req, " value ", nm}, 64'(v), byp ? 64'(cv) : 64'(m_rf[s]));
    endtask

    // One cycle: drive at the falling edge, check before the rising edge, advance model.
    task automatic step(input bit v, input logic [4:0] sa, input logic [4:0] sb,
                        input logic [4:0] dst, input bit wr, input bit br, input bit avail,
                        input bit cv, input bit cbr, input logic [5:0] ct,
                        input logic [31:0] cval);
        bit need, e_fire, e_take, bc;
        logic [5:0] tnew;
        @(negedge clk);
        tnew = pool_next();
        disp_valid = v; disp_src_a = sa; disp_src_b = sb; disp_dst = dst;
        disp_writes = wr; disp_is_branch = br; tag_avail = avail; tag_in = tnew;
        cdb_valid = cv; cdb_is_branch = cbr; cdb_tag = ct; cdb_value = cval;
        #1;
        need   = wr && dst != 0;
        e_fire = v && !m_wait && !(need && !avail);
        e_take = e_fire && need;
        bc     = cv && !cbr;
        if (v && m_wait)            chk("R10 fire", 64'(disp_fire), 64'(e_fire));
        else if (v && need && !avail) chk("R11 fire", 64'(disp_fire), 64'(e_fire));
        else                        chk("R4 fire", 64'(disp_fire), 64'(e_fire));
        chk((v && need) ? "R4 take" : "R12 take", 64'(tag_take), 64'(e_take));
        chk_src("a", sa, bc, ct, cval, src_a_is_tag, src_a_val, src_a_tag);
        chk_src("b", sb, bc, ct, cval, src_b_is_tag, src_b_val, src_b_tag);
        // model update: completion first, then allocation overrides
        if (bc) begin
            for (int j = 1; j < 32; j++) begin
                if (m_busy[j] && m_tag[j] == ct) begin
                    m_rf[j] = cval; m_busy[j] = 0;
                end
            end
        end
        if (e_take) begin
            m_busy[dst] = 1; m_tag[dst] = tnew; tag_ctr = int'(tnew) + 1;
        end
        if (e_fire && br) m_wait = 1;
        else if (cv && cbr) m_wait = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    // Peek one register through source port a (no dispatch, no broadcast).
    task automatic peek(input logic [4:0] r);
        step(0, r, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0] t1, t2, t3, t4;
        void'($urandom(32'd20240611));
        for (int j = 0; j < 32; j++) begin m_busy[j] = 0; m_tag[j] = 0; m_rf[j] = 0; end
        m_wait = 0; tag_ctr = 0;
        rst_n = 0;
        disp_valid = 0; disp_src_a = 0; disp_src_b = 0; disp_dst = 0;
        disp_writes = 0; disp_is_branch = 0; tag_avail = 1; tag_in = 0;
        cdb_valid = 0; cdb_is_branch = 0; cdb_tag = 0; cdb_value = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state of every register
        for (int r = 0; r < 32; r++) begin
            peek(5'(r));
            chk("R1 flag", 64'(src_a_is_tag), 64'd0);
            chk("R1 value", 64'(src_a_val), 64'd0);
        end

        // R6 / R5: two writers to r5, stale broadcast ignored, live one completes
        t1 = pool_next();
        step(1, 1, 2, 5, 1, 0, 1, 0, 0, 0, 0);
        t2 = pool_next();
        step(1, 3, 4, 5, 1, 0, 1, 0, 0, 0, 0);
        step(0, 5, 0, 0, 0, 0, 1, 1, 0, t1, 32'hDEAD_0001);
        peek(5);
        chk("R6 flag", 64'(src_a_is_tag), 64'd1);
        chk("R6 tag", 64'(src_a_tag), 64'(t2));
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, t2, 32'hCAFE_0005);
        peek(5);
        chk("R5 flag", 64'(src_a_is_tag), 64'd0);
        chk("R5 value", 64'(src_a_val), 64'hCAFE_0005);

        // R7: consumer of r6 dispatches while r6's producer broadcasts
        t3 = pool_next();
        step(1, 0, 0, 6, 1, 0, 1, 0, 0, 0, 0);
        step(1, 6, 6, 9, 1, 0, 1, 1, 0, t3, 32'h0000_7777);
        chk("R7 flag", 64'(src_a_is_tag), 64'd0);
        chk("R7 value", 64'(src_b_val), 64'h0000_7777);

        // R8: r7 retagged in the same cycle its old tag completes
        t3 = pool_next();
        step(1, 0, 0, 7, 1, 0, 1, 0, 0, 0, 0);
        t4 = pool_next();
        step(1, 0, 0, 7, 1, 0, 1, 1, 0, t3, 32'h1111_2222);
        peek(7);
        chk("R8 flag", 64'(src_a_is_tag), 64'd1);
        chk("R8 tag", 64'(src_a_tag), 64'(t4));

        // R9: write to r0 takes no tag
        step(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        chk("R9 take", 64'(tag_take), 64'd0);
        peek(0);
        chk("R9 value", 64'(src_a_val), 64'd0);

        // R11 / R12: empty pool stalls a writer, not a store
        step(1, 0, 0, 12, 1, 0, 0, 0, 0, 0, 0);
        chk("R11 stall", 64'(disp_fire), 64'd0);
        step(1, 0, 0, 12, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 store", 64'(disp_fire), 64'd1);
        peek(12);
        chk("R12 untouched", 64'(src_a_is_tag), 64'd0);

        // R10: branch hold until resolution, resume the cycle after
        step(1, 1, 2, 0, 0, 1, 1, 0, 0, 0, 0);
        chk("R10 branch", 64'(disp_fire), 64'd1);
        repeat (3) begin
            step(1, 0, 0, 13, 1, 0, 1, 0, 0, 0, 0);
            chk("R10 held", 64'(disp_fire), 64'd0);
        end
        step(1, 0, 0, 13, 1, 0, 1, 1, 1, 0, 0);
        chk("R10 resolve cycle", 64'(disp_fire), 64'd0);
        step(1, 0, 0, 13, 1, 0, 1, 0, 0, 0, 0);
        chk("R10 resumed", 64'(disp_fire), 64'd1);

        // Seeded random mix
        for (int c = 0; c < 4000; c++) begin
            bit v, wr, br, av, cv, cbr;
            logic [5:0] ct;
            v  = ($urandom % 10) < 7;
            br = ($urandom % 20) == 0;
            wr = br ? 1'b0 : (($urandom % 4) != 0);
            av = ($urandom % 8) != 0;
            cv = ($urandom % 2) == 0;
            cbr = cv && (m_wait ? (($urandom % 3) == 0) : (($urandom % 20) == 0));
            ct = 6'($urandom);
            if (cv && !cbr && ($urandom % 5) != 0) begin
                int st;
                st = int'($urandom % 32);
                for (int k = 0; k < 32; k++) begin
                    int j;
                    j = (st + k) % 32;
                    if (m_busy[j]) begin ct = m_tag[j]; break; end
                end
            end
            step(v, 5'($urandom), 5'($urandom), 5'($urandom), wr, br, av,
                 cv, cbr, ct, $urandom);
        end

        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule